// File: doc/BRIEF.md
# Cyclic Parallel-Prefix End-Around-Carry Adder

This block adds two unsigned words of a parameterised width `WIDTH` and returns their sum modulo 2^WIDTH − 1. This is one's complement addition, as used in residue-number channels, arithmetic error-detecting codes and checksums. The block is purely combinational and has no clock or reset. The width may be any value of two or more, not only a power of two.

Each bit column first forms a generate, a propagate and a half-sum bit. A carry network then computes, for every column, the group generate across all `WIDTH` columns taken cyclically. The span for column i runs from column i downward and wraps from the lowest column to the highest. The network is a Kogge-Stone-style tree. At level l, each column merges its running term with the term held by the column 2^(l−1) places lower, modulo `WIDTH`. Spans that overlap after wrapping reduce to the full-width span, because group terms are idempotent under cyclic overlap. The tree therefore finishes in ceil(log2 WIDTH) levels and needs no extra level to feed the carry-out back in. Each sum bit is the half-sum of its column XORed with the carry of the column just below it. The carry entering column 0 is taken from the top column.

The result uses the usual end-around-carry encoding, so zero has two codes: all zeros and all ones.

Top module: `cyc_mod_adder`

## Requirements
- R1: When a + b < 2^WIDTH, s equals a + b.
- R2: When a + b ≥ 2^WIDTH, s equals a + b − 2^WIDTH + 1. The carry out of the top column is added back in at column 0.
- R3: When a + b = 2^WIDTH − 1 with no column having both operand bits set, s is all ones (the negative-zero code), not all zeros.
- R4: When both operands are all ones, s is all ones.
- R5: For every operand pair, s is congruent to a + b modulo 2^WIDTH − 1. All ones and all zeros both count as zero.
- R6: Widths that are not a power of two (5 and 10) follow R1 and R2 exactly, just as a power-of-two width does.
- R7: The result does not depend on operand order: swapping a and b leaves s unchanged.
- R8: When b is zero, s equals a, including when a is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| s | output | WIDTH | Sum modulo 2^WIDTH − 1, end-around-carry encoded |

## Verification
The bench builds three copies of the adder, with widths 5, 8 and 10.

- **Width 5:** it is a non-power-of-two width, so the cyclic source columns wrap unevenly. It is small enough to sweep exhaustively.
- **Width 8:** this is the default width. It is also swept over every operand pair, which covers every carry pattern, both zero codes, and the step from the plain-sum case to the wrapped case.
- **Width 10:** this is too wide to sweep. It gets random pairs, each also applied in swapped order, plus directed negative-zero, double-all-ones and zero-operand patterns. These exercise a tree whose last level merges spans that overlap after wrapping.

// File: rtl/cmadd_pkg.sv
package cmadd_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair_t;

  // Merge a more significant group term with the one just below it.
  function automatic gpPair_t gpCombine(gpPair_t upper, gpPair_t lower);
    gpPair_t res;
    res.gen  = upper.gen | (upper.prop & lower.gen);
    res.prop = upper.prop & lower.prop;
    return res;
  endfunction

endpackage

// File: rtl/cmadd_pre.sv
module cmadd_pre
  import cmadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  output gpPair_t [WIDTH-1:0] pairs,
  output logic [WIDTH-1:0]    halfSum
);

  for (genvar i = 0; i < WIDTH; i++) begin : col
    assign pairs[i].gen  = opA[i] & opB[i];
    assign pairs[i].prop = opA[i] | opB[i];
    assign halfSum[i]    = opA[i] ^ opB[i];
  end

endmodule

// File: rtl/cmadd_tree.sv
module cmadd_tree
  import cmadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  gpPair_t [WIDTH-1:0] pairs,
  output logic [WIDTH-1:0]    carry
);

  localparam int LEVELS = $clog2(WIDTH);

  // Levels 0 .. LEVELS-1 hold full group terms; the last level only needs generate.
  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    gpPair_t [WIDTH-1:0] term;
    if (l == 0) begin : seed
      assign term = pairs;
    end else begin : merge
      localparam int DIST = 1 << (l - 1);
      for (genvar i = 0; i < WIDTH; i++) begin : col
        localparam int SRC = (i - DIST + WIDTH) % WIDTH;
        assign term[i] = gpCombine(lvl[l-1].term[i], lvl[l-1].term[SRC]);
      end
    end
  end

  localparam int LAST_DIST = 1 << (LEVELS - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : fin
    localparam int SRC = (i - LAST_DIST + WIDTH) % WIDTH;
    assign carry[i] = lvl[LEVELS-1].term[i].gen
                    | (lvl[LEVELS-1].term[i].prop & lvl[LEVELS-1].term[SRC].gen);
  end

endmodule

// File: rtl/cmadd_sum.sv
module cmadd_sum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] halfSum,
  input  logic [WIDTH-1:0] carry,
  output logic [WIDTH-1:0] sum
);

  for (genvar i = 0; i < WIDTH; i++) begin : col
    localparam int BELOW = (i + WIDTH - 1) % WIDTH;
    assign sum[i] = halfSum[i] ^ carry[BELOW];
  end

endmodule

// File: rtl/cyc_mod_adder.sv
module cyc_mod_adder
  import cmadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] s
);

  gpPair_t [WIDTH-1:0] pairs;
  logic [WIDTH-1:0]    halfSum;
  logic [WIDTH-1:0]    carry;

  cmadd_pre #(.WIDTH(WIDTH)) preStage (
    .opA     (a),
    .opB     (b),
    .pairs   (pairs),
    .halfSum (halfSum)
  );

  cmadd_tree #(.WIDTH(WIDTH)) carryNet (
    .pairs (pairs),
    .carry (carry)
  );

  cmadd_sum #(.WIDTH(WIDTH)) sumStage (
    .halfSum (halfSum),
    .carry   (carry),
    .sum     (s)
  );

endmodule

// File: rtl/cyc_mod_adder_chk.sv
module cyc_mod_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] s
);

  localparam longint unsigned MODV = (64'd1 << WIDTH) - 64'd1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    // R1
    r1_plain_sum_chk: assert (wide[WIDTH] || s == wide[WIDTH-1:0]);
    // R2
    r2_wrap_carry_chk: assert (!wide[WIDTH] || s == wide[WIDTH-1:0] + ONE);
    // R3
    r3_neg_zero_chk: assert (!((a & b) == '0 && (a | b) == '1) || s == '1);
    // R4
    r4_double_ones_chk: assert (!(a == '1 && b == '1) || s == '1);
    // R5
    r5_residue_chk: assert ((64'(s) % MODV) == (64'(wide) % MODV));
    // R8
    r8_identity_chk: assert (b != '0 || s == a);
  end

endmodule

bind cyc_mod_adder cyc_mod_adder_chk #(.WIDTH(WIDTH)) chkInst (
  .a (a),
  .b (b),
  .s (s)
);

// File: tb/cyc_mod_adder_test.sv
`timescale 1ns/1ps
module cyc_mod_adder_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] a5, b5, s5;
  logic [7:0] a8, b8, s8;
  logic [9:0] a10, b10, s10;

  cyc_mod_adder #(.WIDTH(5))  uut5 (.a(a5), .b(b5), .s(s5));
  cyc_mod_adder #(.WIDTH(8))  uut  (.a(a8), .b(b8), .s(s8));
  cyc_mod_adder #(.WIDTH(10)) uut10 (.a(a10), .b(b10), .s(s10));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic longint unsigned onesOf(int w);
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic longint unsigned eacRef(longint unsigned av, longint unsigned bv, int w);
    longint unsigned t = av + bv;
    longint unsigned lim = 64'd1 << w;
    return (t >= lim) ? t - lim + 64'd1 : t;
  endfunction

  task automatic checkVal(string req, int w, longint unsigned av, longint unsigned bv,
                          longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s width=%0d a=%0h b=%0h actual=%0h expected=%0h",
               req, w, av, bv, act, exp);
    end
  endtask

  // Drive one pair after a rising edge; return the result at the falling edge.
  task automatic apply(int w, longint unsigned av, longint unsigned bv, output longint unsigned res);
    @(posedge clk);
    case (w)
      5:       begin a5 = av[4:0]; b5 = bv[4:0]; end
      8:       begin a8 = av[7:0]; b8 = bv[7:0]; end
      default: begin a10 = av[9:0]; b10 = bv[9:0]; end
    endcase
    @(negedge clk);
    case (w)
      5:       res = 64'(s5);
      8:       res = 64'(s8);
      default: res = 64'(s10);
    endcase
  endtask

  task automatic testZeroInputs();
    longint unsigned r;
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 5 : (k == 1) ? 8 : 10;
      apply(w, 0, 0, r);
      checkVal("R1 zero inputs", w, 0, 0, r, 0);
    end
  endtask

  task automatic testNegativeZero();
    longint unsigned r;
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 5 : (k == 1) ? 8 : 10;
      longint unsigned pat = 64'h5555_5555 & onesOf(w);
      apply(w, pat, onesOf(w) ^ pat, r);
      checkVal("R3 complementary operands", w, pat, onesOf(w) ^ pat, r, onesOf(w));
      apply(w, onesOf(w), 0, r);
      checkVal("R3 all ones plus zero", w, onesOf(w), 0, r, onesOf(w));
    end
  endtask

  task automatic testDoubleOnes();
    longint unsigned r;
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 5 : (k == 1) ? 8 : 10;
      apply(w, onesOf(w), onesOf(w), r);
      checkVal("R4 both all ones", w, onesOf(w), onesOf(w), r, onesOf(w));
    end
  endtask

  task automatic testIdentity();
    longint unsigned r;
    longint unsigned vals[4] = '{64'd1, 64'd19, 64'd22, 64'd31};
    for (int k = 0; k < 4; k++) begin
      apply(5, vals[k], 0, r);
      checkVal("R8 zero operand", 5, vals[k], 0, r, vals[k]);
      apply(10, vals[k] * 33, 0, r);
      checkVal("R8 zero operand", 10, vals[k] * 33, 0, r, vals[k] * 33);
    end
  endtask

  task automatic testWrapPoint();
    longint unsigned r;
    // One past 2^n: 2^n wraps to 1 (R2); 2^n - 1 stays all ones (R1).
    apply(10, 10'h200, 10'h200, r);
    checkVal("R2 exact 2^n", 10, 10'h200, 10'h200, r, 1);
    apply(10, 10'h3FE, 10'h001, r);
    checkVal("R1 just below 2^n", 10, 10'h3FE, 10'h001, r, 10'h3FF);
    apply(5, 5'd16, 5'd17, r);
    checkVal("R2 odd width wrap", 5, 5'd16, 5'd17, r, 2);
  endtask

  task automatic sweepWidth(int w);
    longint unsigned r;
    longint unsigned lim = 64'd1 << w;
    for (longint unsigned x = 0; x < lim; x++) begin
      for (longint unsigned y = 0; y < lim; y++) begin
        apply(w, x, y, r);
        if (x + y < lim)
          checkVal((w == 5) ? "R1 R6 sweep" : "R1 sweep", w, x, y, r, x + y);
        else
          checkVal((w == 5) ? "R2 R6 sweep" : "R2 sweep", w, x, y, r, eacRef(x, y, w));
        checkVal("R5 residue", w, x, y, r % onesOf(w), (x + y) % onesOf(w));
      end
    end
  endtask

  task automatic randomWide();
    longint unsigned r, rs;
    for (int k = 0; k < 10000; k++) begin
      longint unsigned x = 64'($urandom) & 64'h3FF;
      longint unsigned y = 64'($urandom) & 64'h3FF;
      apply(10, x, y, r);
      checkVal("R6 width ten", 10, x, y, r, eacRef(x, y, 10));
      checkVal("R5 residue", 10, x, y, r % 1023, (x + y) % 1023);
      apply(10, y, x, rs);
      checkVal("R7 swapped operands", 10, y, x, rs, r);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    a5 = '0; b5 = '0; a8 = '0; b8 = '0; a10 = '0; b10 = '0;
    testZeroInputs();
    testNegativeZero();
    testDoubleOnes();
    testIdentity();
    testWrapPoint();
    sweepWidth(5);
    sweepWidth(8);
    randomWide();
    finish();
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

endmodule